// File: doc/BRIEF.md
# Sleep Timer and Watchdog Reset Unit

This block keeps a free-running sleep counter that advances on a slow 32 kHz tick enable, sampled in the system clock domain. Each time the counter completes the selected number of slow ticks, it wraps and raises a one-cycle sleep interrupt. The interrupt serves as a wake-up source in sleep and as a periodic interrupt outside it.

A watchdog counts sleep-counter wraps and pulses a reset on the third wrap since it was last cleared. It stays inert while the power-on status flag is set. Clearing that flag arms the watchdog, and only a new power-on reset can disarm it. The flag is set by power-on reset and can only be cleared by software.

Software services the watchdog by writing to a clear register. Any write restarts the wrap count. One special data value also restarts the sleep counter, which gives an exact three-period timeout. An ordinary clear leaves the sleep counter running, so the timeout that follows lies between two and three periods.

Top module: `sleep_wdt_unit`

## Requirements
- R1: While `por_n` is low and after it rises, `por_flag` is 1, `sleep_irq` and `wdt_rst` are 0, and the sleep counter and wrap count are zero.
- R2: A write with `wr_sel`=1 and data bit 4 equal to 0 clears `por_flag`. A write with data bit 4 equal to 1 leaves the flag unchanged. Nothing but power-on reset sets the flag.
- R3: The watchdog is armed exactly when `por_flag` is 0. While the watchdog is disarmed, `wdt_rst` never pulses, however many wraps occur.
- R4: `period_sel` value s selects a terminal count of 2^(BASE_LOG2 + STEP_LOG2·s) slow ticks. The defaults give 64, 512, 4096 and 32768. `sleep_irq` is high for exactly one cycle, in the cycle after the tick that completes a period.
- R5: `sleep_irq` keeps firing every period whether the watchdog is armed or not.
- R6: While the watchdog is armed, the third wrap since the last clear raises a one-cycle `wdt_rst` in the same cycle as `sleep_irq`. The pulse restarts the wrap count and leaves `por_flag` unchanged.
- R7: Any write with `wr_sel`=0 restarts the wrap count. The sleep counter keeps running unless the data is 0x38. A clear in the same cycle as a wrap wins over that wrap's count.
- R8: A write with `wr_sel`=0 and data 0x38 also restarts the sleep counter in that cycle and suppresses any wrap in that cycle. The next `wdt_rst` then comes exactly three periods later. After an ordinary clear, it comes after more than two and at most three periods.
- R9: A new power-on reset sets `por_flag` again and disarms the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_32k | input | 1 | One-cycle enable per slow clock period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = watchdog clear, 1 = status/control |
| wr_data | input | 8 | Write data |
| period_sel | input | 2 | Sleep period select |
| sleep_irq | output | 1 | One-cycle periodic sleep interrupt |
| wdt_rst | output | 1 | One-cycle watchdog reset request |
| por_flag | output | 1 | Power-on status flag, also the watchdog disarm |

## Verification
The hardest case to reach is the uneven timeout after an ordinary clear. The clear has to land partway through a sleep period so that the leftover part of that period counts toward the timeout. The bench first aligns the counter with the 0x38 clear. It then issues a plain clear a known number of ticks into a period and predicts the tick index of the reset arithmetically, for example half a period plus two full periods. The bench runs the same sweep for every period select on a reduced-size configuration.

// File: rtl/sleep_wdt_unit.sv
module sleep_wdt_unit #(
  parameter int          BASE_LOG2 = 6,
  parameter int          STEP_LOG2 = 3,
  parameter int          FLAG_BIT  = 4,
  parameter logic [7:0]  MAGIC     = 8'h38
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick_32k,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] period_sel,
  output logic       sleep_irq,
  output logic       wdt_rst,
  output logic       por_flag
);
  localparam int CNT_W = BASE_LOG2 + 3 * STEP_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;
  logic [1:0]       wcnt;

  wire clr_wr = wr_en && !wr_sel;
  wire magic  = clr_wr && (wr_data == MAGIC);
  wire armed  = !por_flag;

  assign span  = (CNT_W+1)'(1) << (BASE_LOG2 + STEP_LOG2 * int'(period_sel));
  assign limit = CNT_W'(span - 1'b1);

  wire wrap = tick_32k && !magic && (cnt >= limit);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt <= '0;
    else if (magic) cnt <= '0;
    else if (tick_32k) cnt <= wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wcnt <= '0;
    else if (clr_wr || !armed) wcnt <= '0;
    else if (wrap) wcnt <= (wcnt == 2'd2) ? 2'd0 : wcnt + 2'd1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sleep_irq <= 1'b0;
      wdt_rst   <= 1'b0;
    end else begin
      sleep_irq <= wrap;
      wdt_rst   <= wrap && armed && !clr_wr && (wcnt == 2'd2);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_flag <= 1'b1;
    else if (wr_en && wr_sel && !wr_data[FLAG_BIT]) por_flag <= 1'b0;
  end

  AST_IRQ_PULSE:   assert property (@(posedge clk) disable iff (!por_n) sleep_irq |=> !sleep_irq);   // R4
  AST_WDT_PULSE:   assert property (@(posedge clk) disable iff (!por_n) wdt_rst |=> !wdt_rst);       // R6
  AST_WDT_ON_WRAP: assert property (@(posedge clk) disable iff (!por_n) wdt_rst |-> sleep_irq);      // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n) !por_flag |=> !por_flag);    // R2
  AST_WDT_ARMED:   assert property (@(posedge clk) disable iff (!por_n) wdt_rst |-> !por_flag);      // R3
  AST_WCNT_RANGE:  assert property (@(posedge clk) disable iff (!por_n) wcnt != 2'd3);               // R6
  AST_MAGIC_CLR:   assert property (@(posedge clk) disable iff (!por_n)
                     (wr_en && !wr_sel && wr_data == MAGIC) |=> (cnt == '0 && !sleep_irq));          // R8
  AST_PLAIN_CLR:   assert property (@(posedge clk) disable iff (!por_n)
                     (wr_en && !wr_sel) |=> (wcnt == 2'd0 && !wdt_rst));                             // R7
endmodule

// File: tb/sleep_wdt_unit_tb.sv
module sleep_wdt_unit_tb;
  localparam int BASE = 2;
  localparam int STEP = 1;

  logic clk = 0;
  logic por_n = 0;
  logic tick_32k = 0;
  logic wr_en = 0;
  logic wr_sel = 0;
  logic [7:0] wr_data = '0;
  logic [1:0] period_sel = '0;
  logic sleep_irq, wdt_rst, por_flag;

  int tests = 0, fails = 0;
  int tcount, irq_n, irq_at, wdt_n, wdt_at, long_pulse;

  always #2 clk = ~clk;

  sleep_wdt_unit #(.BASE_LOG2(BASE), .STEP_LOG2(STEP)) u_dut (
    .clk(clk), .por_n(por_n), .tick_32k(tick_32k), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .period_sel(period_sel), .sleep_irq(sleep_irq),
    .wdt_rst(wdt_rst), .por_flag(por_flag));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    tcount = 0; irq_n = 0; irq_at = -1; wdt_n = 0; wdt_at = -1; long_pulse = 0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      tick_32k = 1;
      @(negedge clk);
      tick_32k = 0;
      tcount++;
      if (sleep_irq) begin irq_n++; irq_at = tcount; end
      if (wdt_rst)   begin wdt_n++; if (wdt_at < 0) wdt_at = tcount; end
      @(negedge clk);
      if (sleep_irq || wdt_rst) long_pulse++;
    end
  endtask

  function automatic int tc(input int s);
    return 1 << (BASE + STEP * s);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flag in reset", int'(por_flag), 1);
    chk("R1 irq in reset", int'(sleep_irq), 0);
    por_n = 1;
    @(negedge clk);
    chk("R1 outputs after reset", int'(sleep_irq) + int'(wdt_rst), 0);

    // R4 R5 period sweep, watchdog disarmed (R3)
    for (int s = 0; s < 4; s++) begin
      period_sel = 2'(s);
      wr(1'b0, 8'h38);
      clear_stats();
      run(4 * tc(s));
      chk($sformatf("R4 irq count sel%0d", s), irq_n, 4);
      chk($sformatf("R4 last irq tick sel%0d", s), irq_at, 4 * tc(s));
      chk($sformatf("R3 no wdt while flag set sel%0d", s), wdt_n, 0);
      chk($sformatf("R4 pulse width sel%0d", s), long_pulse, 0);
    end

    // R2 flag writes
    wr(1'b1, 8'hFF);
    chk("R2 bit4=1 keeps flag", int'(por_flag), 1);
    wr(1'b1, 8'hEF);
    chk("R2 bit4=0 clears flag", int'(por_flag), 0);
    wr(1'b1, 8'hFF);
    chk("R2 firmware cannot set flag", int'(por_flag), 0);

    // R6 R8 exact timeout after magic clear, every period
    for (int s = 0; s < 4; s++) begin
      period_sel = 2'(s);
      wr(1'b0, 8'h38);
      clear_stats();
      run(3 * tc(s) + 1);
      chk($sformatf("R8 magic timeout tick sel%0d", s), wdt_at, 3 * tc(s));
      chk($sformatf("R6 single wdt sel%0d", s), wdt_n, 1);
      chk($sformatf("R5 irq while armed sel%0d", s), irq_n, 3);
      chk($sformatf("R6 flag unchanged sel%0d", s), int'(por_flag), 0);
      chk($sformatf("R6 pulse width sel%0d", s), long_pulse, 0);
    end

    // R7 R8 ordinary clear mid-period: timeout of half plus two periods
    for (int s = 0; s < 4; s++) begin
      period_sel = 2'(s);
      wr(1'b0, 8'h38);
      clear_stats();
      run(tc(s) + tc(s) / 2);
      wr(1'b0, 8'h39);
      clear_stats();
      run(3 * tc(s));
      chk($sformatf("R7 plain clear timeout sel%0d", s), wdt_at, tc(s) / 2 + 2 * tc(s));
      chk($sformatf("R8 first irq after plain clear sel%0d", s), irq_n, 3);
    end

    // R6 wrap count restarts after a reset pulse
    period_sel = 2'd0;
    wr(1'b0, 8'h38);
    clear_stats();
    run(6 * tc(0));
    chk("R6 second reset after three more periods", wdt_n, 2);

    // R7 periodic clears keep the watchdog silent
    wr(1'b0, 8'h38);
    clear_stats();
    for (int k = 0; k < 6; k++) begin
      run(2 * tc(0));
      wr(1'b0, 8'h00);
    end
    chk("R7 serviced watchdog silent", wdt_n, 0);
    chk("R7 sleep counter kept running", irq_n, 6 * 2);

    // R9 new power-on reset disarms
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    @(negedge clk);
    chk("R9 flag set by new reset", int'(por_flag), 1);
    clear_stats();
    run(5 * tc(0));
    chk("R9 watchdog disarmed", wdt_n, 0);
    chk("R9 irq continues", irq_n, 5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule